// File: doc/BRIEF.md
# Monitor ADC Status Register Reader

This block drives the register port of an on-chip monitoring ADC. Each time the converter signals that a conversion has finished, the block reads back the status register belonging to the channel that was just converted. It then presents the 12-bit code on a result output, together with the channel number and an end-of-sequence flag.

The register port is timed on a single clock. An access starts with a one-cycle enable and finishes only when the port answers with ready. Conversions that finish while an access is still waiting for ready are stored in a small pending queue and read in order once the port is free. If that queue has no room left, the conversion is dropped and a sticky overrun flag is raised.

A host can also ask to write one of the 32 control words. The host holds its request until it gets a done pulse. A write is started only when no access is outstanding, and in that case it goes ahead of any reads that are still queued.

Top module: `mon_status_reader`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `port_en_o`, `port_we_o`, `res_valid_o`, `host_done_o` and `overrun_o` are all low.
- R2: Suppose `conv_done_i` is sampled high at clock edge k while the block is idle with nothing queued. Then `port_en_o` is high for exactly the one cycle after edge k+1, with `port_we_o` low and `port_addr_o` = {2'b00, channel}.
- R3: Once an access has been issued, `port_en_o` stays low until `port_rdy_i` has been sampled high for that access.
- R4: Suppose `port_rdy_i` is sampled high while a read is outstanding. Then `res_valid_o` is high for exactly the next cycle. In that cycle `res_code_o` equals bits [15:4] of `port_rdata_i` as sampled, and `res_chan_o` is the channel that was read.
- R5: `res_seq_end_o` carries the value that `seq_done_i` had when the matching conversion event was sampled.
- R6: Up to PEND_DEPTH events that arrive while an access is outstanding are queued. They are read in arrival order, and none is lost.
- R7: An event that arrives while the queue is full, in a cycle with no pop, is dropped and sets `overrun_o`. `overrun_o` then stays high until reset.
- R8: A host write drives `port_en_o` and `port_we_o` high for one cycle, with `port_addr_o` = {2'b10, `host_idx_i`} and `port_wdata_o` = `host_data_i`. `host_done_o` pulses for the one cycle after ready is sampled for that write.
- R9: A host write never cuts into an outstanding read. When the port becomes free and a write request and a queued read are both waiting, the write is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | End-of-conversion pulse from the converter |
| seq_done_i | input | 1 | End-of-sequence indication, sampled with conv_done_i |
| conv_chan_i | input | 5 | Channel index of the finished conversion |
| port_en_o | output | 1 | Register port access strobe |
| port_we_o | output | 1 | Register port write select |
| port_addr_o | output | 7 | Register port address |
| port_wdata_o | output | 16 | Register port write data |
| port_rdata_i | input | 16 | Register port read data |
| port_rdy_i | input | 1 | Register port access complete |
| host_req_i | input | 1 | Host control write request, held until done |
| host_idx_i | input | 5 | Control word index (0 to 31) |
| host_data_i | input | 16 | Control word value |
| host_done_o | output | 1 | Host write completed pulse |
| res_valid_o | output | 1 | Result valid pulse |
| res_chan_o | output | 5 | Channel of the result |
| res_code_o | output | 12 | 12-bit conversion code |
| res_seq_end_o | output | 1 | Result closes an automatic sequence |
| overrun_o | output | 1 | Sticky pending-queue overrun |

## Verification
The assertions check the following on every cycle:
- the enable is a single-cycle pulse, and no second enable appears while an access waits for ready;
- every result pulse and every host done pulse follows a ready;
- the queue fill never goes past its depth, and no pop happens on an empty queue;
- the overrun flag, once set, stays set.

Some behaviour can only be shown by the bench's scenarios:
- that results come back in arrival order, with the correct code bits, channel and sequence flag;
- the exact two-edge latency from event to enable;
- that the host write wins over a queued read;
- that the queue holds exactly its depth before the first event is dropped.

// File: rtl/mon_rd_pkg.sv
package mon_rd_pkg;

    parameter int PORT_AW = 7;
    parameter int PORT_DW = 16;
    parameter int CHAN_W  = 5;
    parameter int RES_W   = 12;
    parameter int IDX_W   = 5;

    localparam int PAGE_W = PORT_AW - CHAN_W;
    localparam logic [PAGE_W-1:0] STAT_PAGE = 2'b00;
    localparam logic [PAGE_W-1:0] CTRL_PAGE = 2'b10;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              seq_end;
    } conv_tag_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RD   = 2'd1,
        SQ_WR   = 2'd2
    } sq_state_t;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [RES_W-1:0]  code;
        logic              seq_end;
    } result_t;

    function automatic logic [PORT_AW-1:0] status_addr(input logic [CHAN_W-1:0] ch);
        return {STAT_PAGE, ch};
    endfunction

    function automatic logic [PORT_AW-1:0] ctrl_addr(input logic [IDX_W-1:0] idx);
        return {CTRL_PAGE, idx};
    endfunction

    function automatic logic [RES_W-1:0] code_of(input logic [PORT_DW-1:0] word);
        return word[PORT_DW-1 -: RES_W];
    endfunction

endpackage

// File: rtl/mon_pend_fifo.sv
module mon_pend_fifo
    import mon_rd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  conv_tag_t tag_i,
    input  logic      pop_i,
    output conv_tag_t tag_o,
    output logic      empty_o,
    output logic      overrun_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    conv_tag_t         slots [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              full;
    logic              do_push;
    logic              do_pop;
    logic              ovr_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full || do_pop);
    assign tag_o   = slots[rd_ptr];
    assign overrun_o = ovr_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push_i && full && !do_pop) begin
                ovr_q <= 1'b1;
            end
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);

endmodule

// File: rtl/mon_port_seq.sv
module mon_port_seq
    import mon_rd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pend_empty_i,
    input  conv_tag_t          pend_tag_i,
    output logic               pend_pop_o,
    input  logic               host_req_i,
    input  logic [IDX_W-1:0]   host_idx_i,
    input  logic [PORT_DW-1:0] host_data_i,
    output logic               host_done_o,
    output logic               port_en_o,
    output logic               port_we_o,
    output logic [PORT_AW-1:0] port_addr_o,
    output logic [PORT_DW-1:0] port_wdata_o,
    input  logic               port_rdy_i,
    output logic               rd_take_o,
    output conv_tag_t          rd_tag_o
);

    sq_state_t          state;
    logic               en_q;
    logic               we_q;
    logic [PORT_AW-1:0] addr_q;
    logic [PORT_DW-1:0] wdata_q;
    logic               done_q;
    conv_tag_t          cur_tag;
    logic               start_wr;
    logic               start_rd;

    always_comb begin
        start_wr   = (state == SQ_IDLE) && host_req_i && !done_q;
        start_rd   = (state == SQ_IDLE) && !start_wr && !pend_empty_i;
        pend_pop_o = start_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            en_q    <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            cur_tag <= '0;
        end else begin
            en_q   <= 1'b0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (start_wr) begin
                        state   <= SQ_WR;
                        en_q    <= 1'b1;
                        we_q    <= 1'b1;
                        addr_q  <= ctrl_addr(host_idx_i);
                        wdata_q <= host_data_i;
                    end else if (start_rd) begin
                        state   <= SQ_RD;
                        en_q    <= 1'b1;
                        addr_q  <= status_addr(pend_tag_i.chan);
                        cur_tag <= pend_tag_i;
                    end
                end
                SQ_RD: begin
                    if (port_rdy_i) begin
                        state <= SQ_IDLE;
                    end
                end
                SQ_WR: begin
                    if (port_rdy_i) begin
                        state  <= SQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign port_en_o    = en_q;
    assign port_we_o    = we_q;
    assign port_addr_o  = addr_q;
    assign port_wdata_o = wdata_q;
    assign host_done_o  = done_q;
    assign rd_take_o    = (state == SQ_RD) && port_rdy_i;
    assign rd_tag_o     = cur_tag;

    // R2
    en_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        port_en_o |=> !port_en_o);

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE && !port_rdy_i) |=> !port_en_o);

    // R8
    wr_page_chk: assert property (@(posedge clk) disable iff (rst)
        (port_en_o && port_we_o) |-> (port_addr_o[PORT_AW-1 -: PAGE_W] == CTRL_PAGE));

    // R2
    rd_page_chk: assert property (@(posedge clk) disable iff (rst)
        (port_en_o && !port_we_o) |-> (port_addr_o[PORT_AW-1 -: PAGE_W] == STAT_PAGE));

    // R8
    done_after_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        host_done_o |-> $past(port_rdy_i));

endmodule

// File: rtl/mon_result_reg.sv
module mon_result_reg
    import mon_rd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take_i,
    input  logic [PORT_DW-1:0] word_i,
    input  conv_tag_t          tag_i,
    output result_t            res_o
);

    result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= take_i;
            if (take_i) begin
                res_q.chan    <= tag_i.chan;
                res_q.code    <= code_of(word_i);
                res_q.seq_end <= tag_i.seq_end;
            end
        end
    end

    assign res_o = res_q;

endmodule

// File: rtl/mon_status_reader.sv
module mon_status_reader
    import mon_rd_pkg::*;
#(
    parameter int PEND_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               conv_done_i,
    input  logic               seq_done_i,
    input  logic [CHAN_W-1:0]  conv_chan_i,
    output logic               port_en_o,
    output logic               port_we_o,
    output logic [PORT_AW-1:0] port_addr_o,
    output logic [PORT_DW-1:0] port_wdata_o,
    input  logic [PORT_DW-1:0] port_rdata_i,
    input  logic               port_rdy_i,
    input  logic               host_req_i,
    input  logic [IDX_W-1:0]   host_idx_i,
    input  logic [PORT_DW-1:0] host_data_i,
    output logic               host_done_o,
    output logic               res_valid_o,
    output logic [CHAN_W-1:0]  res_chan_o,
    output logic [RES_W-1:0]   res_code_o,
    output logic               res_seq_end_o,
    output logic               overrun_o
);

    conv_tag_t in_tag;
    conv_tag_t head_tag;
    conv_tag_t rd_tag;
    logic      q_empty;
    logic      q_pop;
    logic      rd_take;
    result_t   res;

    assign in_tag.chan    = conv_chan_i;
    assign in_tag.seq_end = seq_done_i;

    mon_pend_fifo #(.DEPTH(PEND_DEPTH)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .push_i    (conv_done_i),
        .tag_i     (in_tag),
        .pop_i     (q_pop),
        .tag_o     (head_tag),
        .empty_o   (q_empty),
        .overrun_o (overrun_o)
    );

    mon_port_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .pend_empty_i (q_empty),
        .pend_tag_i   (head_tag),
        .pend_pop_o   (q_pop),
        .host_req_i   (host_req_i),
        .host_idx_i   (host_idx_i),
        .host_data_i  (host_data_i),
        .host_done_o  (host_done_o),
        .port_en_o    (port_en_o),
        .port_we_o    (port_we_o),
        .port_addr_o  (port_addr_o),
        .port_wdata_o (port_wdata_o),
        .port_rdy_i   (port_rdy_i),
        .rd_take_o    (rd_take),
        .rd_tag_o     (rd_tag)
    );

    mon_result_reg u_res (
        .clk    (clk),
        .rst    (rst),
        .take_i (rd_take),
        .word_i (port_rdata_i),
        .tag_i  (rd_tag),
        .res_o  (res)
    );

    assign res_valid_o   = res.valid;
    assign res_chan_o    = res.chan;
    assign res_code_o    = res.code;
    assign res_seq_end_o = res.seq_end;

    // R4
    res_after_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(port_rdy_i));

    // R4
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    // R9
    no_dual_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && host_done_o));

endmodule

// File: tb/mon_status_reader_bench.sv
module mon_status_reader_bench;
    import mon_rd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               conv_done = 1'b0;
    logic               seq_done = 1'b0;
    logic [CHAN_W-1:0]  conv_chan = '0;
    logic               port_en;
    logic               port_we;
    logic [PORT_AW-1:0] port_addr;
    logic [PORT_DW-1:0] port_wdata;
    logic [PORT_DW-1:0] port_rdata = '0;
    logic               port_rdy = 1'b0;
    logic               host_req = 1'b0;
    logic [IDX_W-1:0]   host_idx = '0;
    logic [PORT_DW-1:0] host_data = '0;
    logic               host_done;
    logic               res_valid;
    logic [CHAN_W-1:0]  res_chan;
    logic [RES_W-1:0]   res_code;
    logic               res_seq_end;
    logic               overrun;

    int n_checks = 0;
    int n_fails  = 0;
    logic stall = 1'b0;
    conv_tag_t exp_tag [$];
    result_t   exp_res [$];
    logic      txn_log [$];
    logic [IDX_W-1:0]   exp_widx = '0;
    logic [PORT_DW-1:0] exp_wdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_status_reader #(.PEND_DEPTH(DEPTH)) u_mon_status_reader (
        .clk(clk), .rst(rst),
        .conv_done_i(conv_done), .seq_done_i(seq_done), .conv_chan_i(conv_chan),
        .port_en_o(port_en), .port_we_o(port_we), .port_addr_o(port_addr),
        .port_wdata_o(port_wdata), .port_rdata_i(port_rdata), .port_rdy_i(port_rdy),
        .host_req_i(host_req), .host_idx_i(host_idx), .host_data_i(host_data),
        .host_done_o(host_done), .res_valid_o(res_valid), .res_chan_o(res_chan),
        .res_code_o(res_code), .res_seq_end_o(res_seq_end), .overrun_o(overrun)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic result_t make_res(input conv_tag_t t, input logic [PORT_DW-1:0] w);
        result_t r;
        r.valid   = 1'b1;
        r.chan    = t.chan;
        r.code    = w[15:4];
        r.seq_end = t.seq_end;
        return r;
    endfunction

    // Port responder: checks each access, then answers after a random delay.
    initial begin
        conv_tag_t t;
        logic      we;
        int        d;
        t = '0;
        forever begin
            @(negedge clk);
            if (!rst && port_en) begin
                we = port_we;
                txn_log.push_back(we);
                if (!we) begin
                    if (exp_tag.size() == 0) begin
                        chk(1'b0, "R6", "unexpected read addr", 32'(port_addr), 32'hffff);
                    end else begin
                        t = exp_tag.pop_front();
                        chk(port_addr == {2'b00, t.chan}, "R2", "read address",
                            32'(port_addr), 32'({2'b00, t.chan}));
                    end
                end else begin
                    chk(port_addr == {2'b10, exp_widx}, "R8", "write address",
                        32'(port_addr), 32'({2'b10, exp_widx}));
                    chk(port_wdata == exp_wdata, "R8", "write data",
                        32'(port_wdata), 32'(exp_wdata));
                end
                d = $urandom_range(0, 3);
                for (int i = 0; i < d; i++) begin
                    @(negedge clk);
                    chk(!port_en, "R3", "enable while waiting", 32'(port_en), 32'h0);
                end
                while (stall) begin
                    @(negedge clk);
                    chk(!port_en, "R3", "enable while stalled", 32'(port_en), 32'h0);
                end
                port_rdy   = 1'b1;
                port_rdata = 16'($urandom);
                if (!we) exp_res.push_back(make_res(t, port_rdata));
                @(negedge clk);
                port_rdy = 1'b0;
                if (we) chk(host_done, "R8", "done pulse after ready", 32'(host_done), 32'h1);
                else    chk(res_valid, "R4", "valid after ready", 32'(res_valid), 32'h1);
            end
        end
    end

    // Result checker: compares each result with the expected queue.
    initial begin
        result_t e;
        forever begin
            @(negedge clk);
            if (!rst && res_valid) begin
                if (exp_res.size() == 0) begin
                    chk(1'b0, "R4", "unexpected result", 32'(res_chan), 32'hff);
                end else begin
                    e = exp_res.pop_front();
                    chk(res_chan == e.chan, "R6", "result channel order", 32'(res_chan), 32'(e.chan));
                    chk(res_code == e.code, "R4", "result code", 32'(res_code), 32'(e.code));
                    chk(res_seq_end == e.seq_end, "R5", "sequence end flag",
                        32'(res_seq_end), 32'(e.seq_end));
                end
            end
        end
    end

    task automatic send_eoc(input logic [CHAN_W-1:0] ch, input logic se, input logic keep);
        conv_tag_t t;
        conv_done = 1'b1;
        conv_chan = ch;
        seq_done  = se;
        t.chan    = ch;
        t.seq_end = se;
        if (keep) exp_tag.push_back(t);
        @(negedge clk);
        conv_done = 1'b0;
        seq_done  = 1'b0;
    endtask

    task automatic host_write(input logic [IDX_W-1:0] idx, input logic [PORT_DW-1:0] data);
        int guard;
        exp_widx  = idx;
        exp_wdata = data;
        host_idx  = idx;
        host_data = data;
        host_req  = 1'b1;
        guard = 0;
        @(negedge clk);
        while (!host_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        host_req = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while ((exp_tag.size() != 0 || exp_res.size() != 0) && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (6) @(negedge clk);
        chk(exp_tag.size() == 0 && exp_res.size() == 0, "R6", "all events answered",
            32'(exp_tag.size() + exp_res.size()), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!port_en && !port_we && !res_valid && !host_done && !overrun, "R1",
            "outputs during reset", 32'({port_en, port_we, res_valid, host_done, overrun}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!port_en && !res_valid && !overrun, "R1", "outputs after reset",
            32'({port_en, res_valid, overrun}), 32'h0);

        // R2 latency: enable two edges after the event
        send_eoc(5'h00, 1'b0, 1'b1);
        chk(!port_en, "R2", "enable too early", 32'(port_en), 32'h0);
        @(negedge clk);
        chk(port_en && !port_we && port_addr == 7'h00, "R2", "enable for temperature read",
            32'({port_en, port_we, port_addr}), 32'({1'b1, 1'b0, 7'h00}));
        drain();

        // R5 supply channels and sequence end
        send_eoc(5'h01, 1'b0, 1'b1);
        send_eoc(5'h02, 1'b0, 1'b1);
        send_eoc(5'h06, 1'b1, 1'b1);
        drain();

        // R8 host write alone
        host_write(5'h00, 16'h9000);
        host_write(5'h1f, 16'h5111);
        drain();

        // R6 exact capacity: DEPTH queued behind one outstanding
        stall = 1'b1;
        for (int i = 0; i < DEPTH + 1; i++) send_eoc(5'(i + 3), i[0], 1'b1);
        chk(!overrun, "R6", "no overrun at capacity", 32'(overrun), 32'h0);
        stall = 1'b0;
        drain();

        // R7 one more than capacity drops the last event
        stall = 1'b1;
        for (int i = 0; i < DEPTH + 1; i++) send_eoc(5'(i + 16), 1'b0, 1'b1);
        send_eoc(5'h1e, 1'b1, 1'b0);
        chk(overrun, "R7", "overrun set on drop", 32'(overrun), 32'h1);
        stall = 1'b0;
        drain();
        chk(overrun, "R7", "overrun sticky", 32'(overrun), 32'h1);

        // R9 host write waits for read, then beats the queued read
        txn_log.delete();
        stall = 1'b1;
        send_eoc(5'h0d, 1'b0, 1'b1);
        @(negedge clk);
        send_eoc(5'h0e, 1'b0, 1'b1);
        exp_widx  = 5'h02;
        exp_wdata = 16'h0400;
        host_idx  = 5'h02;
        host_data = 16'h0400;
        host_req  = 1'b1;
        repeat (3) @(negedge clk);
        stall = 1'b0;
        while (!host_done) @(negedge clk);
        host_req = 1'b0;
        drain();
        chk(txn_log.size() == 3, "R9", "transaction count", 32'(txn_log.size()), 32'h3);
        if (txn_log.size() == 3)
            chk(txn_log[0] == 1'b0 && txn_log[1] == 1'b1 && txn_log[2] == 1'b0, "R9",
                "read-write-read order", 32'({txn_log[0], txn_log[1], txn_log[2]}), 32'h2);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 19);
            if (r < 7 && exp_tag.size() < DEPTH - 1)
                send_eoc(5'($urandom), 1'($urandom), 1'b1);
            else if (r == 19)
                host_write(5'($urandom), 16'($urandom));
            else
                @(negedge clk);
        end
        drain();

        // R1 / R7 only reset clears overrun
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!overrun && !res_valid && !port_en, "R1", "state after second reset",
            32'({overrun, res_valid, port_en}), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule